// File: doc/BRIEF.md
# Multiplexed MDIO Management Master

This block is an MDIO management master. It runs one PHY register transaction at a time, either a write or a read, onto one of several MDIO segments. Software sets up the transaction through a small word-wide register port. The setup covers the target segment, the PHY address, the write data, the frame style (Clause 22 or Clause 45), the register and device address, and the MDC rate for each segment group. Writing an opcode to the command register starts the transaction. A status flag shows when it has finished, and a read's result is then available in a result register.

The segments form two groups of `BUSES` each, an internal group and an external group. A flag in the parameter register chooses the group, and a bus index chooses the segment inside it. At start the chosen segment and the MDC period are latched, so later register writes do not affect a running transaction. Only the latched segment's MDC toggles, and only its MDIO output enable can be asserted. The frame bits change just after MDC falls. Read data is taken at MDC rising moments. An ownership bit drives a plain output that tells an external management master to stay off the shared wires.

No data stream crosses this block's boundary. The register port, the MDC/MDIO pins and the ownership output are all plain level signals with no valid/ready handshake. The register port accepts a write on every cycle in which `cfg_we` is high, and it never stalls.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset the status register reads 0, every MDC output is low, every MDIO output enable is low and `ext_mstr_block` is low.
- R2: Writing 1 (write) or 2 (read) to the command register at 0x14 while idle starts a transaction. Status bit 0 (done) then reads 0, and it reads 1 once the last frame bit has been sent. Writing 0 to the command register clears done.
- R3: A Clause 22 frame (parameter bit 21 = 0) is made of 32 ones, start 01, opcode 01 for write or 10 for read, the PHY address (parameter bits 20:16, MSB first), the register address (address register bits 4:0), turnaround 10, and 16 data bits (parameter bits 15:0), MSB first.
- R4: A Clause 45 transaction (parameter bit 21 = 1) sends two 64-bit frames back to back. The first is an address frame: 32 ones, 00, 00, PHY address, device address (address register bits 20:16), 10, then the 16-bit register address (address register bits 15:0). The second is a data frame: 32 ones, 00, opcode 01 for write or 11 for read, PHY address, device address, 10, then the data.
- R5: In the final frame of a read, the master releases MDIO (output enable low) from bit 46 through bit 63 of the frame. It captures the input of the selected segment at each MDC rising moment during bits 48 to 63, MSB first. The result register at 0x1C returns the value in bits 15:0, and bits 31:16 read as zero.
- R6: The MDC period in core cycles is divisor × (dividend + 1). The divisor sits in bits 7:0 and the dividend in bits 23:16 of the rate register. Any period below 2 is raised to 2. The register at 0x00 applies to internal segments and the register at 0x04 to external ones.
- R7: When parameter bit 26 is 1, the segment is the bus index in parameter bits 25:22. When it is 0, the segment is 16 plus that index. No other segment's MDC or output enable is ever asserted.
- R8: Writing 0 to the command register during a transaction stops it. From the next cycle all MDC outputs and output enables are low and done stays 0.
- R9: Bit 0 of the ownership register at 0x08 drives `ext_mstr_block`.
- R10: The parameter register at 0x0C and the address register at 0x10 read back the written values in their defined fields, bits 26:0 and 20:0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| ext_mstr_block | output | 1 | Tells an external master to keep off the MDIO wires |
| mdc_o | output | 2*BUSES | Per-segment MDC, index 0..BUSES-1 internal |
| mdio_o | output | 1 | MDIO output value shared by all segments |
| mdio_oe | output | 2*BUSES | Per-segment MDIO output enable |
| mdio_i | input | 2*BUSES | Per-segment MDIO input |

## Verification
A corrupted bit counter or shift register shows up directly on MDIO. Frame bits go out in the wrong order, or there is the wrong number of MDC rising edges before done. The bench sees this on the first affected MDC rising edge, within one MDC period. A wrong latched segment or period shows up within the first MDC period, either as toggling on a segment that should be quiet or as a rise-to-rise interval that differs from divisor × (dividend + 1). Faults in capture or release show up in the result register as soon as the read completes, or as an output enable seen high during the turnaround.

// File: rtl/mdio_mux_pkg.sv
package mdio_mux_pkg;
  localparam logic [4:0] RA_RATE_INT = 5'h00;
  localparam logic [4:0] RA_RATE_EXT = 5'h04;
  localparam logic [4:0] RA_OWN      = 5'h08;
  localparam logic [4:0] RA_PARAM    = 5'h0C;
  localparam logic [4:0] RA_ADDR     = 5'h10;
  localparam logic [4:0] RA_CMD      = 5'h14;
  localparam logic [4:0] RA_STAT     = 5'h18;
  localparam logic [4:0] RA_RESULT   = 5'h1C;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_WR   = 2'd1,
    CMD_RD   = 2'd2
  } cmd_e;

  localparam int FRAME_LEN = 64;
  localparam int TA_BIT    = 46;
  localparam int DATA_BIT  = 48;
endpackage

// File: rtl/mdio_rate_gen.sv
module mdio_rate_gen #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic          mdc,
  output logic          rise,
  output logic          fall
);
  logic [PW-1:0] p_eff;
  logic [PW-1:0] half;
  logic [PW-1:0] cnt;

  assign p_eff = (period < PW'(2)) ? PW'(2) : period;
  assign half  = p_eff >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!run || cnt == p_eff - 1'b1) cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  assign mdc  = run && (cnt >= half);
  assign rise = run && (cnt == half - 1'b1);
  assign fall = run && (cnt == p_eff - 1'b1);

  // R6: a rise event leads to MDC high next cycle unless the run was stopped
  a_r6_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (mdc || !run));
  // R6: a fall event always leaves MDC low next cycle
  a_r6_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  logic        is_rd,
  input  logic        c45,
  input  logic [4:0]  phy,
  input  logic [15:0] regad,
  input  logic [4:0]  dev,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_in,
  output logic        busy,
  output logic        mdio_out,
  output logic        drive,
  output logic        done,
  output logic [15:0] result
);
  function automatic logic [FRAME_LEN-1:0] mk(input logic [1:0] st, input logic [1:0] op,
                                              input logic [4:0] a, input logic [4:0] b,
                                              input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, a, b, 2'b10, d};
  endfunction

  logic [FRAME_LEN-1:0] addr_frm, data_frm, sh;
  logic [5:0]           bitn;
  logic                 last_q, rd_q;

  assign addr_frm = mk(2'b00, 2'b00, phy, dev, regad);
  assign data_frm = c45 ? mk(2'b00, is_rd ? 2'b11 : 2'b01, phy, dev, is_rd ? 16'hFFFF : wdata)
                        : mk(2'b01, is_rd ? 2'b10 : 2'b01, phy, regad[4:0], is_rd ? 16'hFFFF : wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      last_q <= 1'b0;
      rd_q   <= 1'b0;
      bitn   <= '0;
      sh     <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start && !busy) begin
        busy   <= 1'b1;
        rd_q   <= is_rd;
        last_q <= !c45;
        sh     <= c45 ? addr_frm : data_frm;
        bitn   <= '0;
        result <= '0;
      end else if (busy) begin
        if (rise && last_q && rd_q && bitn >= 6'(DATA_BIT))
          result <= {result[14:0], mdio_in};
        if (fall) begin
          if (bitn == 6'(FRAME_LEN - 1)) begin
            if (!last_q) begin
              sh     <= data_frm;
              last_q <= 1'b1;
              bitn   <= '0;
            end else begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end else begin
            sh   <= {sh[FRAME_LEN-2:0], 1'b0};
            bitn <= bitn + 1'b1;
          end
        end
      end
    end
  end

  assign mdio_out = sh[FRAME_LEN-1];
  assign drive    = busy && !(last_q && rd_q && bitn >= 6'(TA_BIT));

  // R3: every frame opens with a preamble one
  a_r3_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mdio_out);
  // R2: completion ends the busy period
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/mdio_seg_steer.sv
module mdio_seg_steer #(
  parameter int NSEG = 32,
  parameter int SW   = 5
) (
  input  logic [SW-1:0]   sel,
  input  logic            en,
  input  logic            mdc,
  input  logic            drive,
  input  logic [NSEG-1:0] mdio_in_vec,
  output logic [NSEG-1:0] mdc_vec,
  output logic [NSEG-1:0] oe_vec,
  output logic            mdio_in_sel
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign mdc_vec[g] = en && mdc   && (sel == SW'(g));
    assign oe_vec[g]  = en && drive && (sel == SW'(g));
  end
  assign mdio_in_sel = mdio_in_vec[sel];
endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master
  import mdio_mux_pkg::*;
#(
  parameter int BUSES = 16,
  parameter int DIVW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [4:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               ext_mstr_block,
  output logic [2*BUSES-1:0] mdc_o,
  output logic               mdio_o,
  output logic [2*BUSES-1:0] mdio_oe,
  input  logic [2*BUSES-1:0] mdio_i
);
  localparam int BW     = $clog2(BUSES);
  localparam int SW     = BW + 1;
  localparam int NSEG   = 2 * BUSES;
  localparam int PW     = 2 * DIVW;
  localparam int IS_POS = 22 + BW;

  logic [DIVW-1:0] ri_div, ri_dd, re_div, re_dd;
  logic            own_q, done_q, job_rd;
  logic [IS_POS:0] param_q, job_param;
  logic [20:0]     addr_q, job_addr;
  logic [1:0]      cmd_q;
  logic [15:0]     result_q, eng_result;
  logic [SW-1:0]   live_seg, job_seg;
  logic [PW-1:0]   live_per, job_per;
  logic            busy, eng_done, mdc, rise, fall, drive, mdio_in_sel;
  logic            cmd_wr, start, abort, live_int;
  logic [IS_POS:0] use_param;
  logic [20:0]     use_addr;

  assign cmd_wr   = cfg_we && cfg_addr == RA_CMD;
  assign start    = cmd_wr && !busy && cfg_wdata[31:2] == '0 &&
                    (cfg_wdata[1:0] == CMD_WR || cfg_wdata[1:0] == CMD_RD);
  assign abort    = cmd_wr && cfg_wdata == '0;
  assign live_int = param_q[IS_POS];
  assign live_seg = live_int ? {1'b0, param_q[22 +: BW]} : {1'b1, param_q[22 +: BW]};
  assign live_per = live_int ? PW'(ri_div) * (PW'(ri_dd) + PW'(1))
                             : PW'(re_div) * (PW'(re_dd) + PW'(1));
  assign use_param = busy ? job_param : param_q;
  assign use_addr  = busy ? job_addr  : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ri_div <= '0; ri_dd <= '0; re_div <= '0; re_dd <= '0;
      own_q <= 1'b0; param_q <= '0; addr_q <= '0; cmd_q <= '0;
      done_q <= 1'b0; result_q <= '0; job_param <= '0; job_addr <= '0;
      job_rd <= 1'b0; job_seg <= '0; job_per <= '0;
    end else begin
      if (cfg_we) begin
        unique case (cfg_addr)
          RA_RATE_INT: begin ri_div <= cfg_wdata[DIVW-1:0]; ri_dd <= cfg_wdata[16 +: DIVW]; end
          RA_RATE_EXT: begin re_div <= cfg_wdata[DIVW-1:0]; re_dd <= cfg_wdata[16 +: DIVW]; end
          RA_OWN:      own_q   <= cfg_wdata[0];
          RA_PARAM:    param_q <= cfg_wdata[IS_POS:0];
          RA_ADDR:     addr_q  <= cfg_wdata[20:0];
          RA_CMD:      if (abort || start) cmd_q <= cfg_wdata[1:0];
          default: ;
        endcase
      end
      if (start) begin
        job_param <= param_q;
        job_addr  <= addr_q;
        job_rd    <= cfg_wdata[1:0] == CMD_RD;
        job_seg   <= live_seg;
        job_per   <= live_per;
        done_q    <= 1'b0;
      end else if (abort) begin
        done_q <= 1'b0;
      end else if (eng_done) begin
        done_q <= 1'b1;
        if (job_rd) result_q <= eng_result;
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_RATE_INT: cfg_rdata = (32'(ri_dd) << 16) | 32'(ri_div);
      RA_RATE_EXT: cfg_rdata = (32'(re_dd) << 16) | 32'(re_div);
      RA_OWN:      cfg_rdata = {31'b0, own_q};
      RA_PARAM:    cfg_rdata = 32'(param_q);
      RA_ADDR:     cfg_rdata = 32'(addr_q);
      RA_CMD:      cfg_rdata = {30'b0, cmd_q};
      RA_STAT:     cfg_rdata = {30'b0, busy, done_q};
      RA_RESULT:   cfg_rdata = {16'b0, result_q};
      default:     cfg_rdata = '0;
    endcase
  end

  assign ext_mstr_block = own_q;

  mdio_rate_gen #(.PW(PW)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy), .period(job_per),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .is_rd(busy ? job_rd : (cfg_wdata[1:0] == CMD_RD)),
    .c45(use_param[21]), .phy(use_param[20:16]), .regad(use_addr[15:0]),
    .dev(use_addr[20:16]), .wdata(use_param[15:0]),
    .rise(rise), .fall(fall), .mdio_in(mdio_in_sel),
    .busy(busy), .mdio_out(mdio_o), .drive(drive), .done(eng_done), .result(eng_result)
  );

  mdio_seg_steer #(.NSEG(NSEG), .SW(SW)) u_steer (
    .sel(job_seg), .en(busy), .mdc(mdc), .drive(drive), .mdio_in_vec(mdio_i),
    .mdc_vec(mdc_o), .oe_vec(mdio_oe), .mdio_in_sel(mdio_in_sel)
  );

  // R2: engine completion is visible in the status flag next cycle
  a_r2_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_q);
  // R8: a zero command silences every segment and keeps done low
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (mdc_o == '0 && mdio_oe == '0 && !done_q));
  // R7: at most one segment clocks or drives at a time
  a_r7_single_seg: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdc_o) && $onehot0(mdio_oe));
  // R7: no segment activity while idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc_o == '0 && mdio_oe == '0));
endmodule

// File: tb/sim_mdio_mux_master.sv
module sim_mdio_mux_master;
  localparam int NSEG = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ext_mstr_block, mdio_o;
  logic [NSEG-1:0] mdc_o, mdio_oe;
  logic [NSEG-1:0] mdio_i = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mdio_mux_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_mstr_block(ext_mstr_block),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R2 watchdog: cycles=%0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [127:0] exp_bits(input bit c45, input bit isrd, input logic [4:0] phy,
                                            input logic [15:0] regad, input logic [4:0] dev,
                                            input logic [15:0] wd);
    logic [63:0] af, df;
    af = {32'hFFFF_FFFF, 2'b00, 2'b00, phy, dev, 2'b10, regad};
    if (c45) begin
      df = {32'hFFFF_FFFF, 2'b00, isrd ? 2'b11 : 2'b01, phy, dev, 2'b10, wd};
      return {af, df};
    end
    df = {32'hFFFF_FFFF, 2'b01, isrd ? 2'b10 : 2'b01, phy, regad[4:0], 2'b10, wd};
    return {df, 64'b0};
  endfunction

  function automatic int exp_period(input int dv, input int dd);
    int p;
    p = dv * (dd + 1);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic txn(input bit isint, input int bus, input bit c45, input bit isrd,
                     input logic [4:0] phy, input logic [15:0] regad, input logic [4:0] dev,
                     input logic [15:0] wd, input int dv, input int dd, input logic [15:0] resp);
    logic [127:0] eb;
    logic [31:0]  st;
    int seg, nbits, base, k, per, last, wait_n, bad_bits, bad_oe, bad_per, bad_iso;
    bit prev, cur;
    seg   = isint ? bus : 16 + bus;
    nbits = c45 ? 128 : 64;
    base  = c45 ? 64 : 0;
    per   = exp_period(dv, dd);
    eb    = exp_bits(c45, isrd, phy, regad, dev, wd);
    wr(isint ? 5'h00 : 5'h04, (32'(dd) << 16) | 32'(dv));
    wr(5'h0C, {5'b0, isint, 4'(bus), c45, phy, wd});
    wr(5'h10, {11'b0, dev, regad});
    wr(5'h14, 32'h0);
    rd(5'h18, st);
    chk(st[0] == 1'b0, "R2", "done after zero command", 64'(st[0]), 64'h0);
    mdio_i = NSEG'($urandom);
    wr(5'h14, isrd ? 32'h2 : 32'h1);
    k = 0; last = 0; prev = 1'b0; wait_n = 0;
    bad_bits = 0; bad_oe = 0; bad_per = 0; bad_iso = 0;
    forever begin
      cur = mdc_o[seg];
      if (((mdc_o | mdio_oe) & ~(NSEG'(1) << seg)) != '0) bad_iso++;
      if (cur && !prev) begin
        if (k < nbits) begin
          automatic bit rel = isrd && (k >= base) && (k - base >= 46);
          if (mdio_oe[seg] != !rel) bad_oe++;
          if (!rel && mdio_o != eb[127-k]) bad_bits++;
        end
        if (k > 0 && (wait_n - last) != per) bad_per++;
        last = wait_n;
        k++;
        mdio_i = NSEG'($urandom);
        if (isrd && k >= base && (k - base) >= 48 && (k - base) < 64)
          mdio_i[seg] = resp[63 - (k - base)];
      end
      prev = cur;
      rd(5'h18, st);
      if (st[0] || wait_n > 4000) break;
      @(negedge clk);
      wait_n++;
    end
    chk(st[0] == 1'b1, "R2", "done after frame", 64'(st[0]), 64'h1);
    chk(k == nbits, c45 ? "R4" : "R3", "MDC rising count", 64'(k), 64'(nbits));
    chk(bad_bits == 0, c45 ? "R4" : "R3", "frame bit mismatches", 64'(bad_bits), 64'h0);
    chk(bad_oe == 0, "R5", "output enable pattern mismatches", 64'(bad_oe), 64'h0);
    chk(bad_per == 0, "R6", "MDC period mismatches", 64'(bad_per), 64'h0);
    chk(bad_iso == 0, "R7", "activity on other segments", 64'(bad_iso), 64'h0);
    if (isrd) begin
      rd(5'h1C, st);
      chk(st == {16'h0, resp}, "R5", "read result", 64'(st), 64'({16'h0, resp}));
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(5'h18, v);
    chk(v == 32'h0, "R1", "status after reset", 64'(v), 64'h0);
    chk(mdc_o == '0 && mdio_oe == '0, "R1", "segment pins after reset",
        64'({mdc_o, mdio_oe}), 64'h0);
    chk(ext_mstr_block == 1'b0, "R1", "ownership after reset", 64'(ext_mstr_block), 64'h0);
    // R9 ownership output
    wr(5'h08, 32'h1);
    chk(ext_mstr_block == 1'b1, "R9", "ownership set", 64'(ext_mstr_block), 64'h1);
    // R10 readback
    wr(5'h0C, 32'h07AB_CDEF);
    rd(5'h0C, v);
    chk(v == 32'h07AB_CDEF, "R10", "parameter readback", 64'(v), 64'h07AB_CDEF);
    wr(5'h10, 32'h001F_1234);
    rd(5'h10, v);
    chk(v == 32'h001F_1234, "R10", "address readback", 64'(v), 64'h001F_1234);
    // directed corner cases
    txn(1, 3,  0, 0, 5'h05, 16'h0011, 5'h00, 16'hA5C3, 2, 1, 16'h0);
    txn(0, 15, 0, 1, 5'h1F, 16'h001E, 5'h00, 16'h0000, 3, 0, 16'h8001);
    txn(1, 0,  1, 0, 5'h00, 16'hFFFF, 5'h1F, 16'h1234, 1, 0, 16'h0);
    txn(0, 7,  1, 1, 5'h0A, 16'h4321, 5'h03, 16'h0000, 0, 3, 16'hBEEF);
    // constrained random
    for (int i = 0; i < 6; i++) begin
      txn(1'($urandom), int'($urandom_range(0, 15)), 1'($urandom), 1'($urandom),
          5'($urandom), 16'($urandom), 5'($urandom), 16'($urandom),
          int'($urandom_range(1, 4)), int'($urandom_range(0, 2)), 16'($urandom));
    end
    // R8 abort mid-frame
    wr(5'h00, 32'h0000_0002);
    wr(5'h0C, 32'h0440_0000);
    wr(5'h14, 32'h2);
    repeat (40) @(negedge clk);
    wr(5'h14, 32'h0);
    chk(mdc_o == '0 && mdio_oe == '0, "R8", "pins after abort",
        64'({mdc_o, mdio_oe}), 64'h0);
    repeat (300) @(negedge clk);
    rd(5'h18, v);
    chk(v == 32'h0, "R8", "status after abort", 64'(v), 64'h0);
    txn(1, 1, 0, 1, 5'h01, 16'h0002, 5'h00, 16'h0, 2, 0, 16'h5A5A);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule